// File: doc/BRIEF.md
# Serial Port Host Register Block

This block is the processor-facing side of a programmable asynchronous serial port. A 3-bit offset together with read and write strobes reaches a small register set. The set holds the outgoing byte for the transmitter, the last byte handed up by the receiver, the interrupt enables, the line control byte, a line status summary, and a cause register for pending interrupts. Bit 7 of the line control byte banks a 16-bit rate divisor over offsets 0 and 1.

From the divisor the block makes a one-cycle tick at sixteen times the bit rate. The tick is used by the serial shifters, which are outside this block. The shifters report back through pulses: a received byte with its error flags, and the transmitter taking the held byte. A level tells whether the transmit shifter is empty. A level tells whether a modem status change is pending. The block combines these into one interrupt request with a fixed priority and a 3-bit cause code. Reading a register clears the condition that the read consumes.

Top module: `uart_regblock`

## Requirements
- R1: After reset, line control, interrupt enable and divisor are 0. The status register at offset 5 reads 0x60 when `tx_shift_empty_i` is 1. The cause register at offset 2 reads 0x01. `irq_o` is low and no tick is produced.
- R2: With line control bit 7 clear, a write to offset 0 loads `thr_data_o` and raises `thr_valid_o`, and a read of offset 0 returns the last received byte. Offset 1 reads back the low 4 bits written, with 0 above them. Offset 3 reads back the full byte and drives `lctl_o`. Offsets 4, 6 and 7 read 0, and writes to them change no register.
- R3: With line control bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes. The held transmit byte and the interrupt enables are left unchanged.
- R4: For a nonzero divisor D, `tick_o` is a one-cycle pulse that repeats every D clock cycles. A divisor of 0 gives no tick.
- R5: Status bit 5 is 1 while no transmit byte is held. Status bit 6 is 1 when bit 5 is 1 and `tx_shift_empty_i` is 1. Bit 7 reads 0.
- R6: A receive pulse sets status bit 0 (data ready) and latches parity error (bit 2), framing error (bit 3) and break (bit 4) from its flags. It sets overrun (bit 1) when data ready was already set. A read of offset 5 clears bits 1 to 4 but not bit 0.
- R7: The cause register returns 0x06 for a line error, 0x04 for received data, 0x02 for transmit holding empty, 0x00 for modem change and 0x01 for none. They are checked in that order of priority, and each counts only when its enable bit is set: bit 2, bit 0, bit 1 and bit 3 of offset 1 in turn.
- R8: Bit 0 of the cause register is 0 exactly when an interrupt is pending, and `irq_o` is high exactly then.
- R9: The transmit-empty interrupt is set when the transmitter takes the held byte, and when enable bit 1 rises while no byte is held. It is cleared by a write to the holding register, or by a read of offset 2 that reports cause 0x02.
- R10: A read of the receive buffer clears data ready, and with it the received-data interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe (side effects on the clock edge) |
| rdata_o | output | 8 | Read data, 0 when no read |
| rx_push_i | input | 1 | Receiver delivers a byte |
| rx_byte_i | input | 8 | Received byte |
| rx_parity_err_i | input | 1 | Parity error flag of the delivered byte |
| rx_frame_err_i | input | 1 | Framing error flag of the delivered byte |
| rx_break_i | input | 1 | Break flag of the delivered byte |
| tx_take_i | input | 1 | Transmitter takes the held byte |
| tx_shift_empty_i | input | 1 | Transmit shifter is idle |
| modem_change_i | input | 1 | Modem status change pending |
| thr_data_o | output | 8 | Held transmit byte |
| thr_valid_o | output | 1 | A transmit byte is held |
| lctl_o | output | 8 | Line control byte for the shifters |
| tick_o | output | 1 | Sixteen-times bit rate tick |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all sixteen enable masks with every interrupt source active. A priority encoder with a wrong order or a wrong code would report the wrong cause for some mask. It measures the tick period for divisors 1 to 20 and for 256, and checks that a divisor of 0 stays silent. A counter that is off by one, or that ignores the high byte, would give a wrong period. It writes data and enable offsets while the divisor bank is open. Missing banking would then corrupt the held byte or the enables. It also runs the clearing sequences. A design that cleared the transmit interrupt on any cause read, or cleared data ready on a status read, would leave the wrong cause pending.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_CAUSE = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_LCTL  = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;

   typedef enum logic [2:0] {
      CAUSE_MODEM  = 3'b000,
      CAUSE_NONE   = 3'b001,
      CAUSE_THRE   = 3'b010,
      CAUSE_RXDATA = 3'b100,
      CAUSE_LINE   = 3'b110
   } cause_e;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] divisor_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (divisor_i != '0) && (cnt_q >= divisor_i - 1'b1);
   assign tick_o = at_end;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (divisor_i == '0)   cnt_q <= '0;
      else if (at_end)            cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_reg_pkg::*;
(
   input  logic   line_req_i,
   input  logic   rx_req_i,
   input  logic   thre_req_i,
   input  logic   modem_req_i,
   output cause_e cause_o,
   output logic   pending_o
);
   always_comb begin
      if (line_req_i)       cause_o = CAUSE_LINE;
      else if (rx_req_i)    cause_o = CAUSE_RXDATA;
      else if (thre_req_i)  cause_o = CAUSE_THRE;
      else if (modem_req_i) cause_o = CAUSE_MODEM;
      else                  cause_o = CAUSE_NONE;
   end
   assign pending_o = (cause_o != CAUSE_NONE);
endmodule

// File: rtl/uart_regblock.sv
module uart_regblock
   import uart_reg_pkg::*;
#(
   parameter int unsigned     DIV_W     = 16,
   parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic [2:0]  addr_i,
   input  logic        wr_en_i,
   input  logic [7:0]  wdata_i,
   input  logic        rd_en_i,
   output logic [7:0]  rdata_o,
   input  logic        rx_push_i,
   input  logic [7:0]  rx_byte_i,
   input  logic        rx_parity_err_i,
   input  logic        rx_frame_err_i,
   input  logic        rx_break_i,
   input  logic        tx_take_i,
   input  logic        tx_shift_empty_i,
   input  logic        modem_change_i,
   output logic [7:0]  thr_data_o,
   output logic        thr_valid_o,
   output logic [7:0]  lctl_o,
   output logic        tick_o,
   output logic        irq_o
);
   localparam int unsigned HI_W     = DIV_W - DATA_W;
   localparam int unsigned N_BYTES  = 2;
   localparam logic [15:0] RST16    = 16'(RESET_DIV);

   if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div_w
      $error("uart_regblock: DIV_W must lie in 9..16");
   end

   logic [7:0]       lctl_q, thr_q, rbr_q;
   logic [3:0]       ien_q;
   logic             dr_q, oe_q, pe_q, fe_q, bi_q, thre_q, thre_irq_q;
   logic [DIV_W-1:0] div_q;
   logic             dlab;
   logic             wr_thr, wr_ien, wr_lctl, rd_rbr, rd_lsr, rd_cause;
   cause_e           cause;
   logic             irq_pend;
   logic [7:0]       lsr, rmux;

   assign dlab     = lctl_q[7];
   assign wr_thr   = wr_en_i && addr_i == OFS_DATA  && !dlab;
   assign wr_ien   = wr_en_i && addr_i == OFS_IEN   && !dlab;
   assign wr_lctl  = wr_en_i && addr_i == OFS_LCTL;
   assign rd_rbr   = rd_en_i && addr_i == OFS_DATA  && !dlab;
   assign rd_lsr   = rd_en_i && addr_i == OFS_LSTAT;
   assign rd_cause = rd_en_i && addr_i == OFS_CAUSE;

   // divisor banks, one per byte, visible only while the bank bit is set
   for (genvar b = 0; b < N_BYTES; b++) begin : g_div_byte
      localparam int unsigned BW = (b == 0) ? DATA_W : HI_W;
      localparam logic [7:0] MASK = 8'((1 << BW) - 1);
      logic [7:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) byte_q <= RST16[b*8 +: 8] & MASK;
         else if (wr_en_i && dlab && addr_i == 3'(b)) byte_q <= wdata_i & MASK;
      end
   end
   assign div_q = {g_div_byte[1].byte_q[HI_W-1:0], g_div_byte[0].byte_q};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lctl_q <= '0;
         ien_q  <= '0;
         thr_q  <= '0;
      end else begin
         if (wr_lctl) lctl_q <= wdata_i;
         if (wr_ien)  ien_q  <= wdata_i[3:0];
         if (wr_thr)  thr_q  <= wdata_i;
      end
   end

   // receive side: byte, data ready and sticky line errors
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rbr_q <= '0;
         dr_q  <= 1'b0;
         oe_q  <= 1'b0;
         pe_q  <= 1'b0;
         fe_q  <= 1'b0;
         bi_q  <= 1'b0;
      end else begin
         if (rd_lsr) begin
            oe_q <= 1'b0;
            pe_q <= 1'b0;
            fe_q <= 1'b0;
            bi_q <= 1'b0;
         end
         if (rd_rbr) dr_q <= 1'b0;
         if (rx_push_i) begin
            rbr_q <= rx_byte_i;
            dr_q  <= 1'b1;
            if (dr_q)            oe_q <= 1'b1;
            if (rx_parity_err_i) pe_q <= 1'b1;
            if (rx_frame_err_i)  fe_q <= 1'b1;
            if (rx_break_i)      bi_q <= 1'b1;
         end
      end
   end

   // transmit holding state and its interrupt flag
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thre_q     <= 1'b1;
         thre_irq_q <= 1'b0;
      end else begin
         if (wr_thr) begin
            thre_q     <= 1'b0;
            thre_irq_q <= 1'b0;
         end else if (tx_take_i) begin
            thre_q     <= 1'b1;
            thre_irq_q <= 1'b1;
         end else if (wr_ien && wdata_i[1] && !ien_q[1] && thre_q) begin
            thre_irq_q <= 1'b1;
         end else if (rd_cause && cause == CAUSE_THRE) begin
            thre_irq_q <= 1'b0;
         end
      end
   end

   uart_irq_prio u_prio (
      .line_req_i  (ien_q[2] && (oe_q || pe_q || fe_q || bi_q)),
      .rx_req_i    (ien_q[0] && dr_q),
      .thre_req_i  (ien_q[1] && thre_irq_q),
      .modem_req_i (ien_q[3] && modem_change_i),
      .cause_o     (cause),
      .pending_o   (irq_pend)
   );

   uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .divisor_i (div_q),
      .tick_o    (tick_o)
   );

   assign lsr = {1'b0, thre_q && tx_shift_empty_i, thre_q, bi_q, fe_q, pe_q, oe_q, dr_q};

   always_comb begin
      case (addr_i)
         OFS_DATA:  rmux = dlab ? g_div_byte[0].byte_q : rbr_q;
         OFS_IEN:   rmux = dlab ? g_div_byte[1].byte_q : {4'b0, ien_q};
         OFS_CAUSE: rmux = {5'b0, cause};
         OFS_LCTL:  rmux = lctl_q;
         OFS_LSTAT: rmux = lsr;
         default:   rmux = '0;
      endcase
   end

   assign rdata_o     = rd_en_i ? rmux : '0;
   assign thr_data_o  = thr_q;
   assign thr_valid_o = !thre_q;
   assign lctl_o      = lctl_q;
   assign irq_o       = irq_pend;
endmodule

// File: rtl/uart_regblock_chk.sv
module uart_regblock_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [2:0]       addr_i,
   input logic             wr_en_i,
   input logic [7:0]       wdata_i,
   input logic             rd_en_i,
   input logic [7:0]       rdata_o,
   input logic             rx_push_i,
   input logic             tx_take_i,
   input logic [7:0]       thr_data_o,
   input logic             thr_valid_o,
   input logic [7:0]       lctl_o,
   input logic             tick_o,
   input logic             irq_o,
   input logic             dr_q,
   input logic             oe_q,
   input logic [DIV_W-1:0] div_q
);
   a_r2_thr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 3'd0 && !lctl_o[7]) |=> (thr_valid_o && thr_data_o == $past(wdata_i)));

   a_r3_banked_thr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 3'd0 && lctl_o[7]) |=> $stable(thr_data_o));

   a_r4_zero_div_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_q == '0) |-> !tick_o);

   a_r6_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_push_i && dr_q) |=> oe_q);

   a_r8_cause_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == 3'd2) |-> (rdata_o[0] == !irq_o));

   a_r9_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_take_i && !(wr_en_i && addr_i == 3'd0 && !lctl_o[7])) |=> !thr_valid_o);

   a_r10_read_clears_dr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && addr_i == 3'd0 && !lctl_o[7] && !rx_push_i) |=> !dr_q);
endmodule

bind uart_regblock uart_regblock_chk #(.DIV_W(DIV_W)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .addr_i      (addr_i),
   .wr_en_i     (wr_en_i),
   .wdata_i     (wdata_i),
   .rd_en_i     (rd_en_i),
   .rdata_o     (rdata_o),
   .rx_push_i   (rx_push_i),
   .tx_take_i   (tx_take_i),
   .thr_data_o  (thr_data_o),
   .thr_valid_o (thr_valid_o),
   .lctl_o      (lctl_o),
   .tick_o      (tick_o),
   .irq_o       (irq_o),
   .dr_q        (dr_q),
   .oe_q        (oe_q),
   .div_q       (div_q)
);

// File: tb/uart_regblock_tb_top.sv
module uart_regblock_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] addr;
   logic       wr_en, rd_en;
   logic [7:0] wdata, rdata;
   logic       rx_push, rx_pe, rx_fe, rx_bi;
   logic [7:0] rx_byte;
   logic       tx_take, tx_sh_empty, modem;
   logic [7:0] thr_data, lctl;
   logic       thr_valid, tick, irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   uart_regblock dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
      .rd_en_i(rd_en), .rdata_o(rdata), .rx_push_i(rx_push), .rx_byte_i(rx_byte),
      .rx_parity_err_i(rx_pe), .rx_frame_err_i(rx_fe), .rx_break_i(rx_bi),
      .tx_take_i(tx_take), .tx_shift_empty_i(tx_sh_empty), .modem_change_i(modem),
      .thr_data_o(thr_data), .thr_valid_o(thr_valid), .lctl_o(lctl),
      .tick_o(tick), .irq_o(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, int'(v), int'(exp));
   endtask

   task automatic push(input logic [7:0] b, input logic pe, input logic fe, input logic bi);
      @(negedge clk); rx_push = 1'b1; rx_byte = b; rx_pe = pe; rx_fe = fe; rx_bi = bi;
      @(negedge clk); rx_push = 1'b0; rx_pe = 1'b0; rx_fe = 1'b0; rx_bi = 1'b0;
   endtask

   task automatic take();
      @(negedge clk); tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic set_div(input logic [15:0] d);
      wr(3'd3, 8'h83);
      wr(3'd0, d[7:0]);
      wr(3'd1, d[15:8]);
      wr(3'd3, 8'h03);
   endtask

   // cycles between two consecutive ticks, 0 if none within the window
   task automatic period(output int p);
      int seen = 0;
      p = 0;
      for (int i = 0; i < 2000 && seen == 0; i++) begin
         @(negedge clk);
         if (tick) seen = 1;
      end
      if (seen != 0) begin
         for (int i = 1; i <= 2000 && p == 0; i++) begin
            @(negedge clk);
            if (tick) p = i;
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int cnt, p;
      logic [7:0] v;
      rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
      rx_push = 0; rx_pe = 0; rx_fe = 0; rx_bi = 0; rx_byte = '0;
      tx_take = 0; tx_sh_empty = 1'b1; modem = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rdchk("R1 status", 3'd5, 8'h60);
      rdchk("R1 cause", 3'd2, 8'h01);
      rdchk("R1 lctl", 3'd3, 8'h00);
      rdchk("R1 ien", 3'd1, 8'h00);
      chk("R1 irq", int'(irq), 0);
      cnt = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (tick) cnt++; end
      chk("R1 no tick", cnt, 0);

      // R2 offset map
      wr(3'd3, 8'h1B);
      rdchk("R2 lctl readback", 3'd3, 8'h1B);
      chk("R2 lctl_o", int'(lctl), 8'h1B);
      wr(3'd0, 8'hA5);
      chk("R2 thr data", int'(thr_data), 8'hA5);
      chk("R2 thr valid", int'(thr_valid), 1);
      rdchk("R5 status held byte", 3'd5, 8'h00);
      take();
      chk("R9 take empties", int'(thr_valid), 0);
      wr(3'd1, 8'hF0);
      rdchk("R2 ien upper zero", 3'd1, 8'h00);
      wr(3'd4, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
      rdchk("R2 offset4", 3'd4, 8'h00);
      rdchk("R2 offset6", 3'd6, 8'h00);
      rdchk("R2 offset7", 3'd7, 8'h00);
      rdchk("R2 lctl untouched", 3'd3, 8'h1B);
      rdchk("R2 ien untouched", 3'd1, 8'h00);

      // R3 banking
      wr(3'd3, 8'h9B);
      wr(3'd0, 8'h0C);
      wr(3'd1, 8'h00);
      rdchk("R3 div low", 3'd0, 8'h0C);
      rdchk("R3 div high", 3'd1, 8'h00);
      chk("R3 thr kept", int'(thr_data), 8'hA5);
      chk("R3 thr not loaded", int'(thr_valid), 0);
      wr(3'd3, 8'h1B);
      rdchk("R3 ien kept", 3'd1, 8'h00);
      period(p);
      chk("R4 period 12", p, 12);

      // R4 divisor sweep
      for (int d = 1; d <= 20; d++) begin
         set_div(16'(d));
         period(p);
         chk("R4 period", p, d);
      end
      set_div(16'h0100);
      period(p);
      chk("R4 period 256", p, 256);
      set_div(16'h0000);
      period(p);
      chk("R4 zero divisor", p, 0);

      // R5 shifter state
      tx_sh_empty = 1'b0;
      rdchk("R5 shifter busy", 3'd5, 8'h20);
      tx_sh_empty = 1'b1;

      // R6 and R10 receive status
      push(8'h3C, 0, 0, 0);
      rdchk("R6 data ready", 3'd5, 8'h61);
      rdchk("R10 rx byte", 3'd0, 8'h3C);
      rdchk("R10 dr cleared", 3'd5, 8'h60);
      push(8'h11, 0, 0, 0);
      push(8'h22, 1, 0, 0);
      rdchk("R6 overrun parity", 3'd5, 8'h67);
      rdchk("R6 errors cleared", 3'd5, 8'h61);
      push(8'h33, 0, 1, 1);
      rdchk("R10 last byte", 3'd0, 8'h33);
      rdchk("R6 frame break overrun", 3'd5, 8'h7A);
      rdchk("R6 all clear", 3'd5, 8'h60);

      // R7/R8 priority sweep with every source active
      push(8'h55, 1, 0, 0);
      modem = 1'b1;
      for (int m = 0; m < 16; m++) begin
         logic [3:0] e;
         logic [7:0] exp;
         e = 4'(m);
         exp = e[2] ? 8'h06 : e[0] ? 8'h04 : e[1] ? 8'h02 : e[3] ? 8'h00 : 8'h01;
         wr(3'd1, 8'(m));
         wr(3'd0, 8'h40 + 8'(m));
         take();
         chk("R8 irq level", int'(irq), (m != 0) ? 1 : 0);
         rdchk("R7 cause", 3'd2, exp);
      end

      // R9/R10 clearing sequence, ien = 0xF
      rdchk("R7 clear line", 3'd5, 8'h65);
      rdchk("R7 rx after line", 3'd2, 8'h04);
      rdchk("R10 rx byte", 3'd0, 8'h55);
      rdchk("R9 thre reported", 3'd2, 8'h02);
      rdchk("R9 thre cleared by read", 3'd2, 8'h00);
      modem = 1'b0;
      rdchk("R8 none pending", 3'd2, 8'h01);
      chk("R8 irq low", int'(irq), 0);

      // R9 enable edge, write clears, take sets
      wr(3'd1, 8'h00);
      wr(3'd1, 8'h02);
      chk("R9 enable sets", int'(irq), 1);
      wr(3'd0, 8'h77);
      rdchk("R9 write clears", 3'd2, 8'h01);
      take();
      rdchk("R9 take sets", 3'd2, 8'h02);

      // R7 disabled source stays silent
      wr(3'd1, 8'h00);
      modem = 1'b1;
      @(negedge clk);
      chk("R7 modem masked", int'(irq), 0);
      rdchk("R7 modem masked cause", 3'd2, 8'h01);
      modem = 1'b0;

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule